// File: doc/BRIEF.md
# Branch Resolution Stall Checker

This block sits beside the branch unit and decides, once per cycle, whether the branch that decode presents can be resolved without holding up instruction fetch. It looks at the kind of branch and at its condition inputs. It also looks at three availability flags: the link register, the counter register and a shadow copy of the link register that a link-writing branch fills. It then reports either a go or a stall, and for a stall a single reason code.

The block keeps one bit of state: whether a branch whose CR condition was not yet known has gone ahead on a prediction that is not yet confirmed. Only one such guess may be in flight. While it is pending, any branch that tests a CR bit, and any branch that would need a second guess, is held. The bit is cleared by a resolve pulse from the execution side or at once by a flush. All results are registered, so they appear one clock after the inputs that caused them.

Top module: `brs_stall_chk`

## Requirements
- R1: Reset (active low, synchronous) drives `go`, `stall`, `stall_why` and `pred_pending` to 0, including when a prediction was pending.
- R2: A branch of kind 1 (target from link register) stalls with reason 1 when `lr_avail` is 0.
- R3: A branch of kind 2 (target from counter register) stalls with reason 2 when `ctr_avail` is 0.
- R4: A branch with `br_link` set stalls with reason 3 when `slr_avail` is 0, unless a higher-priority reason applies.
- R5: A branch of kind 3 (counter decrement and CR) stalls with reason 2 unless `ctr_avail` is 1, or `cr_ready` is 1 and `cr_true` is 0.
- R6: A branch of kind 4 (CR only) stalls with reason 4 while `pred_pending` is 1, whether or not its CR bit is ready.
- R7: A branch of kind 3 or 4 with `cr_ready` 0 needs a prediction. It stalls with reason 4 while `pred_pending` is 1. When it goes, `pred_pending` is 1 in the same cycle that `go` rises.
- R8: A `resolve` pulse clears `pred_pending` on the next edge. A `flush` clears it and forces `go` and `stall` to 0 on the next edge, and it takes priority over everything else.
- R9: When several reasons apply, the code reported follows the priority link register (1) > counter (2) > shadow link (3) > unresolved (4). Kinds 0 and 5 to 7 have no needs beyond the shadow link check.
- R10: Outputs follow their inputs by one clock. With `br_valid` 0, `go`, `stall` and `stall_why` are 0. With `br_valid` 1 and no flush, exactly one of `go` and `stall` is 1, and `stall_why` is nonzero exactly when `stall` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid | input | 1 | A decoded branch is presented this cycle |
| br_kind | input | 3 | 0 plain, 1 to link reg, 2 to counter, 3 counter-decrement and CR, 4 CR only |
| br_link | input | 1 | The branch writes the link register |
| cr_ready | input | 1 | The CR bit the branch tests is known |
| cr_true | input | 1 | Value of that CR condition when known |
| lr_avail | input | 1 | Link register value is available |
| ctr_avail | input | 1 | Counter register value is available |
| slr_avail | input | 1 | Shadow link register is free |
| resolve | input | 1 | The outstanding predicted branch has been resolved |
| flush | input | 1 | Pipeline flush; drops the branch and the pending guess |
| go | output | 1 | Branch resolved without a stall (registered) |
| stall | output | 1 | Branch must stall (registered) |
| stall_why | output | 3 | 0 none, 1 link reg, 2 counter, 3 shadow link, 4 unresolved guess |
| pred_pending | output | 1 | A predicted branch is outstanding |

## Verification
The assertions assume that every input is held at a known value during and after reset. They also assume that `resolve` comes from a branch that the block actually let through on a guess. They never treat a resolve pulse that arrives while no guess is pending as an error, because such a pulse only leaves the clear flag clear. The bench drives every input at the falling edge from a vector table and keeps `br_valid` low during reset. It raises `resolve` and `flush` only as single-cycle pulses, so every property sees one well-defined input set per edge.

// File: rtl/brs_pkg.sv
// Package: shared encodings for the branch resolution stall checker.
// Assumes a 3-bit kind field and a 3-bit reason field.
package brs_pkg;
    localparam int KIND_W = 3;
    localparam int WHY_W  = 3;

    typedef enum logic [KIND_W-1:0] {
        BK_PLAIN  = 3'd0,
        BK_TO_LR  = 3'd1,
        BK_TO_CTR = 3'd2,
        BK_CTR_CR = 3'd3,
        BK_CR     = 3'd4
    } br_kind_e;

    typedef enum logic [WHY_W-1:0] {
        WHY_NONE  = 3'd0,
        WHY_LR    = 3'd1,
        WHY_CTR   = 3'd2,
        WHY_SLR   = 3'd3,
        WHY_UNRES = 3'd4
    } why_e;
endpackage

// File: rtl/brs_decode.sv
// Module: combinational stall decision for one presented branch.
// Assumes pending reflects the registered guess state of this cycle;
// reasons are chosen by fixed priority LR > CTR > shadow LR > unresolved.
module brs_decode
    import brs_pkg::*;
(
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    input  logic              link,
    input  logic              cr_ready,
    input  logic              cr_true,
    input  logic              lr_avail,
    input  logic              ctr_avail,
    input  logic              slr_avail,
    input  logic              pending,
    output logic              go_d,
    output logic              stall_d,
    output logic [WHY_W-1:0]  why_d,
    output logic              issue_pred
);
    logic lr_miss, ctr_miss, slr_miss, unres_hit, cr_dep, need_pred;

    // Per-resource shortfalls for this branch.
    always_comb begin
        cr_dep    = (kind == BK_CTR_CR) || (kind == BK_CR);
        need_pred = cr_dep && !cr_ready;
        lr_miss   = (kind == BK_TO_LR) && !lr_avail;
        ctr_miss  = ((kind == BK_TO_CTR) && !ctr_avail) ||
                    ((kind == BK_CTR_CR) && !(ctr_avail || (cr_ready && !cr_true)));
        slr_miss  = link && !slr_avail;
        unres_hit = pending && ((kind == BK_CR) || need_pred);
    end

    // Priority selection of the single reported reason.
    always_comb begin
        why_d = WHY_NONE;
        if (valid) begin
            if (lr_miss)        why_d = WHY_LR;
            else if (ctr_miss)  why_d = WHY_CTR;
            else if (slr_miss)  why_d = WHY_SLR;
            else if (unres_hit) why_d = WHY_UNRES;
        end
        stall_d    = valid && (why_d != WHY_NONE);
        go_d       = valid && (why_d == WHY_NONE);
        issue_pred = go_d && need_pred;
    end
endmodule

// File: rtl/brs_pend.sv
// Module: one-deep outstanding-prediction flag.
// Assumes set and clear never refer to the same guess; flush wins over both,
// set wins over clear so a new guess issued alongside a resolve survives.
module brs_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic flush_i,
    output logic pend_o
);
    // Hold, set or clear the guess-in-flight bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_o <= 1'b0;
        else if (flush_i) pend_o <= 1'b0;
        else if (set_i)   pend_o <= 1'b1;
        else if (clr_i)   pend_o <= 1'b0;
    end
endmodule

// File: rtl/brs_stall_chk.sv
// Module: top of the branch resolution stall checker.
// Decides go/stall per cycle from branch kind and resource flags, registers
// the result one cycle later, and tracks a single outstanding predicted branch.
// Assumes inputs are synchronous to clk; flush drops the presented branch.
module brs_stall_chk
    import brs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [KIND_W-1:0] br_kind,
    input  logic              br_link,
    input  logic              cr_ready,
    input  logic              cr_true,
    input  logic              lr_avail,
    input  logic              ctr_avail,
    input  logic              slr_avail,
    input  logic              resolve,
    input  logic              flush,
    output logic              go,
    output logic              stall,
    output logic [WHY_W-1:0]  stall_why,
    output logic              pred_pending
);
    logic             go_d, stall_d, issue_pred;
    logic [WHY_W-1:0] why_d;

    brs_decode u_dec (
        .valid      (br_valid),
        .kind       (br_kind),
        .link       (br_link),
        .cr_ready   (cr_ready),
        .cr_true    (cr_true),
        .lr_avail   (lr_avail),
        .ctr_avail  (ctr_avail),
        .slr_avail  (slr_avail),
        .pending    (pred_pending),
        .go_d       (go_d),
        .stall_d    (stall_d),
        .why_d      (why_d),
        .issue_pred (issue_pred)
    );

    brs_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (issue_pred),
        .clr_i   (resolve),
        .flush_i (flush),
        .pend_o  (pred_pending)
    );

    // Register the decision; a flush discards the presented branch.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            go        <= 1'b0;
            stall     <= 1'b0;
            stall_why <= WHY_NONE;
        end else begin
            go        <= go_d;
            stall     <= stall_d;
            stall_why <= why_d;
        end
    end
endmodule

// File: rtl/brs_stall_chk_sva.sv
// Module: property checker for brs_stall_chk, attached by bind below.
// Assumes inputs are known from reset onward.
module brs_stall_chk_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       br_valid,
    input logic [2:0] br_kind,
    input logic       br_link,
    input logic       cr_ready,
    input logic       cr_true,
    input logic       lr_avail,
    input logic       ctr_avail,
    input logic       slr_avail,
    input logic       resolve,
    input logic       flush,
    input logic       go,
    input logic       stall,
    input logic [2:0] stall_why,
    input logic       pred_pending
);
    logic past_ok;

    // Marks that the previous edge saw reset released, so $past is meaningful.
    always_ff @(posedge clk) past_ok <= rst_n;

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ($onehot0({go, stall}) && (stall == (stall_why != 3'd0))));

    assert_valid_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(flush)) |-> ((go || stall) == $past(br_valid)));

    assert_lr_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(br_valid && br_kind == 3'd1 && !lr_avail && !flush))
        |-> (stall && stall_why == 3'd1));

    assert_ctr_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(br_valid && br_kind == 3'd2 && !ctr_avail && !flush))
        |-> (stall && stall_why == 3'd2));

    assert_ctrcr_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(br_valid && br_kind == 3'd3 && !ctr_avail &&
                          !(cr_ready && !cr_true) && !flush))
        |-> (stall && stall_why == 3'd2));

    assert_slr_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(br_valid && br_link && !slr_avail && !flush))
        |-> (stall && stall_why != 3'd0 && stall_why <= 3'd3));

    assert_cr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(br_valid && br_kind == 3'd4 && pred_pending && !flush))
        |-> stall);

    assert_guess_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && go && $past((br_kind == 3'd3 || br_kind == 3'd4) && !cr_ready))
        |-> pred_pending);

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(flush)) |-> (!pred_pending && !go && !stall));

    assert_resolve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(resolve && !br_valid)) |-> !pred_pending);
endmodule

bind brs_stall_chk brs_stall_chk_sva u_sva (.*);

// File: tb/brs_stall_chk_tb.sv
`timescale 1ns/1ps
module brs_stall_chk_tb;
    localparam int NV = 19;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       br_valid, br_link, cr_ready, cr_true;
    logic [2:0] br_kind;
    logic       lr_avail, ctr_avail, slr_avail, resolve, flush;
    logic       go, stall, pred_pending;
    logic [2:0] stall_why;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    brs_stall_chk u_dut (.*);

    // Layout: valid kind[3] link crrdy crtrue lr ctr slr resolve flush | go stall why[3] pend
    localparam logic [17:0] VEC [NV] = '{
        18'b1_001_0_1_0_0_1_1_0_0_0_1_001_0,  // 0  R2 LR missing
        18'b1_001_0_1_0_1_1_1_0_0_1_0_000_0,  // 1  R2 LR present
        18'b1_010_0_1_0_1_0_1_0_0_0_1_010_0,  // 2  R3 CTR missing
        18'b1_000_1_1_0_1_1_0_0_0_0_1_011_0,  // 3  R4 shadow missing
        18'b1_001_1_1_0_0_1_0_0_0_0_1_001_0,  // 4  R9 LR over shadow
        18'b1_011_0_1_1_1_0_1_0_0_0_1_010_0,  // 5  R5 CR true, no CTR
        18'b1_011_0_1_0_1_0_1_0_0_1_0_000_0,  // 6  R5 CR false proceeds
        18'b1_100_0_0_0_1_1_1_0_0_1_0_000_1,  // 7  R7 guess issued
        18'b1_100_0_1_1_1_1_1_0_0_0_1_100_1,  // 8  R6 CR branch held
        18'b1_011_0_0_0_1_1_1_0_0_0_1_100_1,  // 9  R7 second guess held
        18'b1_010_0_1_0_1_1_1_0_0_1_0_000_1,  // 10 R9 CTR branch unaffected
        18'b0_000_0_1_0_1_1_1_1_0_0_0_000_0,  // 11 R8 resolve clears
        18'b1_011_0_0_0_1_1_1_0_0_1_0_000_1,  // 12 R7 guess again
        18'b1_100_0_0_0_1_1_1_0_1_0_0_000_0,  // 13 R8 flush
        18'b1_010_1_1_0_1_0_0_0_0_0_1_010_0,  // 14 R9 CTR over shadow
        18'b1_100_1_0_0_1_1_0_0_0_0_1_011_0,  // 15 R4 stall sets no guess
        18'b1_101_0_1_0_0_0_1_0_0_1_0_000_0,  // 16 R9 kind 5 plain
        18'b1_011_1_0_0_1_1_1_0_0_1_0_000_1,  // 17 R4 shadow free, guess
        18'b1_100_0_0_0_1_1_1_1_0_0_1_100_0   // 18 R10 held while resolving
    };

    // Requirement tag for each vector, used in failure lines.
    function automatic string tag_of(int i);
        case (i)
            0, 1:       return "R2";
            2:          return "R3";
            3, 15, 17:  return "R4";
            5, 6:       return "R5";
            8:          return "R6";
            7, 9, 12:   return "R7";
            11, 13:     return "R8";
            4, 10, 14, 16: return "R9";
            default:    return "R10";
        endcase
    endfunction

    task automatic drive(input logic [17:0] v);
        br_valid  = v[17];
        br_kind   = v[16:14];
        br_link   = v[13];
        cr_ready  = v[12];
        cr_true   = v[11];
        lr_avail  = v[10];
        ctr_avail = v[9];
        slr_avail = v[8];
        resolve   = v[7];
        flush     = v[6];
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {go, stall, stall_why, pred_pending};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {go,stall,why,pend} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #80000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        drive(18'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 6'b0);               // R1 state after reset
        rst_n = 1'b1;
        drive(VEC[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(tag_of(i), VEC[i][5:0]);
            if (i + 1 < NV) drive(VEC[i + 1]);
            else drive(18'b0);
        end
        // R10 idle cycle gives no decision
        @(negedge clk);
        check("R10", 6'b0);
        // R1 reset while a guess is pending
        drive(18'b1_100_0_0_0_1_1_1_0_0_0_0_000_0);
        @(negedge clk);
        check("R7", 6'b100001);
        drive(18'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 6'b0);
        rst_n = 1'b1;
        // R8 flush beats a new guess in the same cycle
        drive(18'b1_100_0_0_0_1_1_1_0_1_0_0_000_0);
        @(negedge clk);
        check("R8", 6'b0);
        drive(18'b0);
        @(negedge clk);
        finish_run();
    end
endmodule